// File: doc/BRIEF.md
# Dual-Core Package Hot Throttle Controller

This block brings together the over-temperature trips of two processor cores into one shared package hot line. The line is active low and bidirectional. The block drives the pad whenever either core trips. It also senses the pad, so an outside agent can pull the line low and the cores will throttle even when neither of them is hot. The pad is modelled as an output enable (`hot_pad_oe`, which pulls the line low when set) plus a sensed input (`hot_pad_in`).

Two throttle policies exist:

- **Clock modulation.** Only a core that is over its trip point has its clock enable gated. The gate runs at a fixed 50% duty over a programmable period.
- **Performance state.** Both cores request the lowest programmed performance state, whichever core tripped.

If both policies are enabled, performance-state mode wins. Throttling is held for a programmable number of cycles after the hot condition clears. A one-cycle interrupt pulse can be enabled separately for the asserting edge and the deasserting edge of the sensed line.

Every pin is a plain level-type control or status pin. No data stream passes through the block, so it has no valid/ready handshake and nothing that applies back-pressure.

Top module: `pkg_hot_throttle`

## Requirements
- R1: `hot_pad_oe` is high in the same cycle that any bit of `core_trip` is high, and low otherwise.
- R2: The pad is sampled through two flops as hot = NOT `hot_pad_in`. A sensed hot level that arrives while `hot_pad_oe` was low two samples earlier is treated as an external assertion. An external assertion throttles both cores under the active policy.
- R3: With only `clkmod_en` set, only a core whose own trip (or an external assertion) is active gets its `core_clk_en` bit gated. The other core's bit stays at 1.
- R4: With `pstate_en` set and the package throttle active, every slice of `pstate_req` (core i at bits i*PS_W upward) equals `pstate_low`. Otherwise every slice equals `pstate_nom`.
- R5: `hot_irq` pulses for one cycle after a rising edge of the sensed hot level when `irq_rise_en` is set. It pulses for one cycle after a falling edge when `irq_fall_en` is set.
- R6: A throttle tracker (one per core and one for the package) becomes active on the edge after its hot input is seen. It stays active for as long as that input stays high.
- R7: When clock modulation starts on a core, `core_clk_en` is 0 for H cycles and then 1 for H cycles, repeating. H is `mod_half`, and a value of 0 is taken as 1.
- R8: With both `pstate_en` and `clkmod_en` set, performance-state mode applies to both cores and `core_clk_en` stays all ones.
- R9: A tracker releases at the end of the `hold_cycles`-th consecutive cycle with its hot input low. A value of 0 behaves as 1.
- R10: After reset, `hot_pad_oe` and `hot_irq` are 0, `core_clk_en` is all ones, and `pstate_req` carries `pstate_nom`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_trip | input | NCORE | Per-core over-temperature trip |
| clkmod_en | input | 1 | Enable clock-modulation policy |
| pstate_en | input | 1 | Enable performance-state policy |
| irq_rise_en | input | 1 | Interrupt on sensed assertion |
| irq_fall_en | input | 1 | Interrupt on sensed deassertion |
| hold_cycles | input | HOLD_W | Release hysteresis in cycles |
| mod_half | input | PER_W | Half period of the clock gate |
| pstate_nom | input | PS_W | Performance state when not throttled |
| pstate_low | input | PS_W | Lowest programmed performance state |
| hot_pad_oe | output | 1 | Pad driver enable (pulls the line low) |
| hot_pad_in | input | 1 | Sensed pad level (low = hot) |
| core_clk_en | output | NCORE | Per-core clock enable |
| pstate_req | output | NCORE*PS_W | Per-core performance-state request |
| hot_irq | output | 1 | Interrupt pulse on sensed edges |

## Verification
`hot_pad_oe` follows the trips in the same cycle. Every other result comes from the two-flop sensed level and from one more register after it. So a trip or an external pull presented before rising edge k changes `core_clk_en`, `pstate_req` and `hot_irq` just after edge k+2. Release follows `hold_cycles` edges after the sensed level falls. The bench drives inputs on the falling edge. It advances its reference model on every rising edge, using a delay queue and integer counters. It compares all outputs a quarter period after each falling edge, so every comparison sees the settled values for the current cycle.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    POL_NONE   = 2'd0,
    POL_CLKMOD = 2'd1,
    POL_PSTATE = 2'd2
  } thr_policy_e;

  // Performance-state mode outranks clock modulation.
  function automatic thr_policy_e pick_policy(input logic cm_en, input logic ps_en);
    if (ps_en) return POL_PSTATE;
    if (cm_en) return POL_CLKMOD;
    return POL_NONE;
  endfunction

endpackage

// File: rtl/hot_pad_sense.sv
module hot_pad_sense #(
  parameter int NCORE = 2,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] trip_i,
  input  logic             pad_in_i,
  output logic             pad_oe_o,
  output logic             pkg_hot_o,
  output logic [NCORE-1:0] core_hot_o
);

  logic [SYNC-1:0]            sense_q;
  logic [SYNC-1:0]            oe_q;
  logic [SYNC-1:0][NCORE-1:0] trip_q;
  logic                       ext_hot;

  assign pad_oe_o = |trip_i;

  // The trips and the drive enable are delayed as far as the sensed pad,
  // so that a sensed hot level can be split into own drive and external pull.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      oe_q    <= '0;
      trip_q  <= '0;
    end else begin
      sense_q <= {sense_q[SYNC-2:0], ~pad_in_i};
      oe_q    <= {oe_q[SYNC-2:0], pad_oe_o};
      trip_q  <= {trip_q[SYNC-2:0], trip_i};
    end
  end

  assign ext_hot    = sense_q[SYNC-1] & ~oe_q[SYNC-1];
  assign pkg_hot_o  = sense_q[SYNC-1];
  assign core_hot_o = trip_q[SYNC-1] | {NCORE{ext_hot}};

endmodule

// File: rtl/hot_edge_irq.sv
module hot_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic irq_o
);

  logic prev_q;
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= hot_i;
      irq_q  <= (hot_i & ~prev_q & rise_en_i) | (~hot_i & prev_q & fall_en_i);
    end
  end

  assign irq_o = irq_q;

  // R5: a pulse is only ever raised for a change of the sensed level.
  p_irq_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(hot_i) != $past(prev_q)));

endmodule

// File: rtl/throttle_hold.sv
module throttle_hold #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hot_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              active_o
);

  logic [HOLD_W-1:0] cnt_q;
  logic              act_q;
  logic [HOLD_W:0]   cnt_nx;
  logic              keep;

  always_comb begin
    cnt_nx = {1'b0, cnt_q} + 1'b1;
    keep   = cnt_nx < {1'b0, hold_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (hot_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && keep) begin
      cnt_q <= cnt_nx[HOLD_W-1:0];
    end else begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end
  end

  assign active_o = act_q;

  p_hot_sets_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> act_q);

  // R9: release never happens on a cycle where the hot input was high.
  p_release_after_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> !$past(hot_i));

endmodule

// File: rtl/clk_duty_gate.sv
module clk_duty_gate #(
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_i,
  input  logic [PER_W-1:0] half_i,
  output logic             clk_en_o
);

  localparam int CW = PER_W + 1;

  logic [CW-1:0] pc_q;
  logic [CW-1:0] half_eff;
  logic [CW-1:0] last;

  always_comb begin
    half_eff = (half_i == '0) ? CW'(1) : {1'b0, half_i};
    last     = (half_eff << 1) - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (!on_i)      pc_q <= '0;
    else if (pc_q >= last) pc_q <= '0;
    else                 pc_q <= pc_q + CW'(1);
  end

  assign clk_en_o = ~on_i | (pc_q >= half_eff);

  // R7: every modulation burst opens with the gated-off half.
  p_gate_starts_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_i) |-> !clk_en_o);

endmodule

// File: rtl/pkg_hot_throttle.sv
module pkg_hot_throttle
  import thr_pkg::*;
#(
  parameter int NCORE  = 2,
  parameter int HOLD_W = 8,
  parameter int PER_W  = 6,
  parameter int PS_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      core_trip,
  input  logic                  clkmod_en,
  input  logic                  pstate_en,
  input  logic                  irq_rise_en,
  input  logic                  irq_fall_en,
  input  logic [HOLD_W-1:0]     hold_cycles,
  input  logic [PER_W-1:0]      mod_half,
  input  logic [PS_W-1:0]       pstate_nom,
  input  logic [PS_W-1:0]       pstate_low,
  output logic                  hot_pad_oe,
  input  logic                  hot_pad_in,
  output logic [NCORE-1:0]      core_clk_en,
  output logic [NCORE*PS_W-1:0] pstate_req,
  output logic                  hot_irq
);

  logic             pkg_hot;
  logic [NCORE-1:0] core_hot;
  logic             pkg_act;
  logic [NCORE-1:0] core_act;
  thr_policy_e      policy;

  assign policy = pick_policy(clkmod_en, pstate_en);

  hot_pad_sense #(.NCORE(NCORE), .SYNC(2)) u_sense (
    .clk(clk), .rst_n(rst_n), .trip_i(core_trip), .pad_in_i(hot_pad_in),
    .pad_oe_o(hot_pad_oe), .pkg_hot_o(pkg_hot), .core_hot_o(core_hot));

  hot_edge_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hot_i(pkg_hot), .rise_en_i(irq_rise_en),
    .fall_en_i(irq_fall_en), .irq_o(hot_irq));

  throttle_hold #(.HOLD_W(HOLD_W)) u_pkg_hold (
    .clk(clk), .rst_n(rst_n), .hot_i(pkg_hot), .hold_i(hold_cycles),
    .active_o(pkg_act));

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    logic mod_on;

    throttle_hold #(.HOLD_W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .hot_i(core_hot[g]), .hold_i(hold_cycles),
      .active_o(core_act[g]));

    assign mod_on = (policy == POL_CLKMOD) && core_act[g];

    clk_duty_gate #(.PER_W(PER_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .on_i(mod_on), .half_i(mod_half),
      .clk_en_o(core_clk_en[g]));

    assign pstate_req[g*PS_W +: PS_W] =
      ((policy == POL_PSTATE) && pkg_act) ? pstate_low : pstate_nom;
  end

  // R8: with both policies on, no core clock is ever gated.
  p_pstate_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_en && clkmod_en) |-> (core_clk_en == {NCORE{1'b1}}));

endmodule

// File: tb/pkg_hot_throttle_test.sv
`timescale 1ns/1ps
module pkg_hot_throttle_test;

  localparam int NC = 2, HW = 8, PW = 6, SW = 4;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] core_trip = '0;
  logic clkmod_en = 0, pstate_en = 0, irq_rise_en = 0, irq_fall_en = 0;
  logic [HW-1:0] hold_cycles = 8'd3;
  logic [PW-1:0] mod_half = 6'd2;
  logic [SW-1:0] pstate_nom = 4'd5, pstate_low = 4'd1;
  logic hot_pad_oe, hot_pad_in, hot_irq, ext_drive = 0;
  logic [NC-1:0] core_clk_en;
  logic [NC*SW-1:0] pstate_req;

  int vectors = 0, misses = 0, cycles = 0;
  string tag = "R10";

  always #10 clk = ~clk;

  assign hot_pad_in = ~(hot_pad_oe | ext_drive);

  pkg_hot_throttle uut (
    .clk(clk), .rst_n(rst_n), .core_trip(core_trip), .clkmod_en(clkmod_en),
    .pstate_en(pstate_en), .irq_rise_en(irq_rise_en), .irq_fall_en(irq_fall_en),
    .hold_cycles(hold_cycles), .mod_half(mod_half), .pstate_nom(pstate_nom),
    .pstate_low(pstate_low), .hot_pad_oe(hot_pad_oe), .hot_pad_in(hot_pad_in),
    .core_clk_en(core_clk_en), .pstate_req(pstate_req), .hot_irq(hot_irq));

  // reference model state
  int hist[$];
  int act[3];   // 0,1 cores; 2 package
  int cnt[3];
  int pc[2];
  int prev_hot = 0, irq_m = 0;

  function automatic int half_eff();
    return (mod_half == 0) ? 1 : int'(mod_half);
  endfunction

  function automatic bit mod_on(int i);
    return clkmod_en && !pstate_en && act[i] != 0;
  endfunction

  task automatic track(int i, int hot);
    int lim;
    lim = int'(hold_cycles);
    if (hot != 0) begin act[i] = 1; cnt[i] = 0; end
    else if (act[i] != 0) begin
      cnt[i]++;
      if (cnt[i] >= lim) begin act[i] = 0; cnt[i] = 0; end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < 3; i++) begin act[i] = 0; cnt[i] = 0; end
      pc[0] = 0; pc[1] = 0; prev_hot = 0; irq_m = 0;
    end else begin
      int dv, hot, ext, h;
      hist.push_back({28'd0, core_trip, ext_drive, (|core_trip)});
      dv = (hist.size() > 2) ? hist.pop_front() : 0;
      hot = ((dv & 1) | ((dv >> 1) & 1));
      ext = ((dv >> 1) & 1) & ~(dv & 1) & 1;
      h = half_eff();
      for (int i = 0; i < 2; i++) begin
        if (!mod_on(i)) pc[i] = 0;
        else if (pc[i] >= 2*h-1) pc[i] = 0;
        else pc[i]++;
      end
      irq_m = ((hot != 0 && prev_hot == 0 && irq_rise_en) ||
               (hot == 0 && prev_hot != 0 && irq_fall_en)) ? 1 : 0;
      prev_hot = hot;
      for (int i = 0; i < 2; i++) track(i, ((dv >> (2+i)) & 1) | ext);
      track(2, hot);
    end
  end

  task automatic chk(string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s [%s] at cycle %0d: got %0d expected %0d", what, tag, cycles, got, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #5;
    cycles++;
    if (rst_n) begin
      int h, ps;
      h = half_eff();
      chk("R1 hot_pad_oe", int'(hot_pad_oe), int'(|core_trip));
      for (int i = 0; i < 2; i++) begin
        chk("R3/R7 core_clk_en", int'(core_clk_en[i]), (!mod_on(i) || pc[i] >= h) ? 1 : 0);
        ps = (pstate_en && act[2] != 0) ? int'(pstate_low) : int'(pstate_nom);
        chk("R4 pstate_req", int'(pstate_req[i*SW +: SW]), ps);
      end
      chk("R5 hot_irq", int'(hot_irq), irq_m);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1;
    tag = "R10"; wait_cyc(3);
    // R1: pad drive alone, no policy
    tag = "R1"; core_trip = 2'b01; wait_cyc(3); core_trip = 2'b10; wait_cyc(2);
    core_trip = 2'b00; wait_cyc(8);
    // R3: clock modulation only on tripped core
    tag = "R3"; clkmod_en = 1; core_trip = 2'b01; wait_cyc(12); core_trip = 0; wait_cyc(12);
    core_trip = 2'b11; wait_cyc(9); core_trip = 0; wait_cyc(10);
    // R7: other half periods including 0
    tag = "R7"; mod_half = 6'd3; core_trip = 2'b10; wait_cyc(16); core_trip = 0; wait_cyc(10);
    mod_half = 6'd0; core_trip = 2'b01; wait_cyc(8); core_trip = 0; wait_cyc(8);
    mod_half = 6'd2;
    // R4: performance-state mode
    tag = "R4"; clkmod_en = 0; pstate_en = 1; core_trip = 2'b10; wait_cyc(8); core_trip = 0; wait_cyc(10);
    // R8: both modes
    tag = "R8"; clkmod_en = 1; core_trip = 2'b01; wait_cyc(10); core_trip = 0; wait_cyc(10);
    // R2: external pull in each policy
    tag = "R2"; pstate_en = 0; ext_drive = 1; wait_cyc(10); ext_drive = 0; wait_cyc(10);
    clkmod_en = 0; pstate_en = 1; ext_drive = 1; wait_cyc(6); ext_drive = 0; wait_cyc(10);
    clkmod_en = 1; pstate_en = 0; core_trip = 2'b01; ext_drive = 1; wait_cyc(6);
    core_trip = 0; wait_cyc(6); ext_drive = 0; wait_cyc(10);
    // R5: interrupt edges
    tag = "R5"; irq_rise_en = 1; core_trip = 2'b10; wait_cyc(5); core_trip = 0; wait_cyc(6);
    irq_rise_en = 0; irq_fall_en = 1; core_trip = 2'b01; wait_cyc(5); core_trip = 0; wait_cyc(6);
    irq_rise_en = 1; ext_drive = 1; wait_cyc(1); ext_drive = 0; wait_cyc(6);
    irq_rise_en = 0; irq_fall_en = 0;
    // R9 / R6: hold lengths
    tag = "R9"; hold_cycles = 8'd0; core_trip = 2'b01; wait_cyc(6); core_trip = 0; wait_cyc(6);
    hold_cycles = 8'd6; core_trip = 2'b10; wait_cyc(3); core_trip = 0; wait_cyc(12);
    tag = "R6"; clkmod_en = 0; pstate_en = 1; core_trip = 2'b01; wait_cyc(2);
    core_trip = 0; wait_cyc(2); core_trip = 2'b01; wait_cyc(2); core_trip = 0; wait_cyc(14);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog [%s]: got timeout expected completion", tag);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule